// File: doc/BRIEF.md
# Field event interrupt status and mask unit

This unit sits beside a video timing core and turns its field events into one level-sensitive interrupt request. Every event input has a sticky status bit that latches on a pulse, whatever the mask says. A mask register picks which pending bits may drive the interrupt line. The line is high while any bit is both pending and enabled.

Software never writes status or mask as a whole word. Status bits are acknowledged by writing ones to a clear address. The mask has separate set and clear addresses. In each case only the bits written as 1 change, so two agents can own different bits without a read-modify-write race. Bit 0 carries the bottom-field event and bit 1 the top-field event. The other event inputs are reserved but latch the same way.

Top module: `fld_irq_unit`

## Requirements
- R1: Reset (rst_n low, asynchronous) sets status and mask to all zeros and drives irq_o low.
- R2: A 1 on ev_i bit k at a rising clock edge sets status bit k. The mask does not affect this, and the bit stays set until it is cleared. Bit 0 is the bottom-field event, bit 1 the top-field event, and bits 2 to 15 are reserved events that latch the same way.
- R3: A write to the status clear address (3'd1) clears each status bit written as 1 and leaves the other status bits unchanged.
- R4: If an event and a status clear hit the same bit at the same edge, the event wins and the bit stays set.
- R5: A write to the mask set address (3'd4) sets each mask bit written as 1. A write to the mask clear address (3'd3) clears each mask bit written as 1. All other mask bits keep their value.
- R6: irq_o is high exactly when some bit is set in both status and mask. Unmasking a pending bit raises irq_o right after the write edge.
- R7: With rd_en high, rdata shows status at address 3'd0 and mask at address 3'd2, combinationally from the registers, so a read in the cycle after a write returns the updated value. Other addresses, or rd_en low, give zero.
- R8: A write to a read-only address (3'd0, 3'd2) or to an unmapped address (3'd5 to 3'd7) changes neither status nor mask.
- R9: Writing 0xFFFF to the status clear or mask clear address empties that whole 16-bit register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register bus |
| rd_en | input | 1 | Read strobe for the register bus |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data, one bit per event |
| rdata | output | 16 | Read data |
| ev_i | input | 16 | Event pulses from the timing core |
| irq_o | output | 1 | Level interrupt request |

## Verification
A wrong status or mask bit reaches the ports in the cycle after the edge that corrupted it. It shows in rdata at that register's address, and in irq_o whenever the matching bit of the other register is set. A lost event, a clear that reaches unwritten bits, or a clear that beats a simultaneous event therefore shows up within one clock. Each stimulus step reads back both registers and the interrupt line before the next edge. Mask-only and status-only faults are told apart by driving patterns where just one of the two registers has the bit set.

// File: rtl/fld_irq_pkg.sv
package fld_irq_pkg;

    localparam int FLD_ADDR_W = 3;
    localparam int FLD_REG_W  = 16;

    // bit positions the timing core drives
    localparam int FLD_EV_BOTTOM = 0;
    localparam int FLD_EV_TOP    = 1;

    typedef enum logic [FLD_ADDR_W-1:0] {
        A_STAT     = 3'd0,
        A_STAT_CLR = 3'd1,
        A_MASK     = 3'd2,
        A_MASK_CLR = 3'd3,
        A_MASK_SET = 3'd4
    } fld_addr_e;

    typedef struct packed {
        logic stat_clr;
        logic mask_clr;
        logic mask_set;
    } fld_wstrobe_t;

endpackage

// File: rtl/fld_irq_regif.sv
module fld_irq_regif
    import fld_irq_pkg::*;
#(
    parameter int REG_W  = FLD_REG_W,
    parameter int ADDR_W = FLD_ADDR_W
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  stat,
    input  logic [REG_W-1:0]  mask,
    output fld_wstrobe_t      strobe,
    output logic [REG_W-1:0]  rdata
);

    always_comb begin
        strobe          = '0;
        strobe.stat_clr = wr_en && (addr == A_STAT_CLR);
        strobe.mask_clr = wr_en && (addr == A_MASK_CLR);
        strobe.mask_set = wr_en && (addr == A_MASK_SET);
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == A_STAT)      rdata = stat;
            else if (addr == A_MASK) rdata = mask;
        end
    end

endmodule

// File: rtl/fld_irq_status.sv
module fld_irq_status #(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] ev_i,
    input  logic             clr_en,
    input  logic [REG_W-1:0] clr_bits,
    output logic [REG_W-1:0] stat_o
);

    typedef struct packed {
        logic [REG_W-1:0] bits;
    } stat_t;

    stat_t            st_d, st_q;
    logic [REG_W-1:0] nxt_bit;

    // one sticky cell per event; a new event overrides a clear
    for (genvar i = 0; i < REG_W; i++) begin : g_cell
        assign nxt_bit[i] = ev_i[i] | (st_q.bits[i] & ~(clr_en & clr_bits[i]));
    end

    always_comb begin
        st_d      = st_q;
        st_d.bits = nxt_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.bits;

endmodule

// File: rtl/fld_irq_mask.sv
module fld_irq_mask #(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [REG_W-1:0] bits_i,
    output logic [REG_W-1:0] mask_o
);

    typedef struct packed {
        logic [REG_W-1:0] bits;
    } mask_t;

    mask_t mk_d, mk_q;

    always_comb begin
        mk_d = mk_q;
        if (set_en) mk_d.bits = mk_d.bits | bits_i;
        if (clr_en) mk_d.bits = mk_d.bits & ~bits_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mk_q <= '0;
        else        mk_q <= mk_d;
    end

    assign mask_o = mk_q.bits;

endmodule

// File: rtl/fld_irq_unit.sv
module fld_irq_unit
    import fld_irq_pkg::*;
#(
    parameter int REG_W  = FLD_REG_W,
    parameter int ADDR_W = FLD_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic [REG_W-1:0]  ev_i,
    output logic              irq_o
);

    fld_wstrobe_t     strobe;
    logic [REG_W-1:0] stat_vec;
    logic [REG_W-1:0] mask_vec;

    fld_irq_regif #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_regif (
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .stat   (stat_vec),
        .mask   (mask_vec),
        .strobe (strobe),
        .rdata  (rdata)
    );

    fld_irq_status #(.REG_W(REG_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_i     (ev_i),
        .clr_en   (strobe.stat_clr),
        .clr_bits (wdata),
        .stat_o   (stat_vec)
    );

    fld_irq_mask #(.REG_W(REG_W)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (strobe.mask_set),
        .clr_en (strobe.mask_clr),
        .bits_i (wdata),
        .mask_o (mask_vec)
    );

    assign irq_o = |(stat_vec & mask_vec);

endmodule

// File: rtl/fld_irq_unit_chk.sv
module fld_irq_unit_chk
    import fld_irq_pkg::*;
#(
    parameter int REG_W  = FLD_REG_W,
    parameter int ADDR_W = FLD_ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [REG_W-1:0]  wdata,
    input logic [REG_W-1:0]  ev_i,
    input logic [REG_W-1:0]  stat_vec,
    input logic [REG_W-1:0]  mask_vec,
    input logic              irq_o
);

    logic is_sclr, is_mclr, is_mset, is_wr_mapped;
    assign is_sclr      = wr_en && (addr == A_STAT_CLR);
    assign is_mclr      = wr_en && (addr == A_MASK_CLR);
    assign is_mset      = wr_en && (addr == A_MASK_SET);
    assign is_wr_mapped = is_sclr || is_mclr || is_mset;

    AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i != '0) |=> ((stat_vec & $past(ev_i)) == $past(ev_i))); // R2

    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !is_sclr |=> ((stat_vec & $past(stat_vec)) == $past(stat_vec))); // R2

    AST_STAT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        is_sclr |=> ((stat_vec & $past(wdata & ~ev_i)) == '0)); // R3

    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sclr && ((wdata & ev_i) != '0)) |=> ((stat_vec & $past(wdata & ev_i)) != '0)); // R4

    AST_MASK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        is_mset |=> ((mask_vec & $past(wdata)) == $past(wdata))); // R5

    AST_MASK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        is_mclr |=> ((mask_vec & $past(wdata)) == '0)); // R5

    AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_vec == '0) |-> !irq_o); // R6

    AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_wr_mapped && (ev_i == '0)) |=> ($stable(stat_vec) && $stable(mask_vec))); // R8

endmodule

bind fld_irq_unit fld_irq_unit_chk #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .ev_i     (ev_i),
    .stat_vec (stat_vec),
    .mask_vec (mask_vec),
    .irq_o    (irq_o)
);

// File: tb/fld_irq_unit_test.sv
module fld_irq_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [15:0] ev_i = '0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fld_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ev_i(ev_i), .irq_o(irq_o)
    );

    typedef struct packed {
        logic        wr;
        logic [2:0]  a;
        logic [15:0] d;
        logic [15:0] ev;
        logic [15:0] est;
        logic [15:0] emk;
        logic        eirq;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd0, 16'h0000, 16'h0001, 16'h0001, 16'h0000, 1'b0}, // R2 bottom latches while masked
        '{1'b1, 3'd4, 16'h0001, 16'h0000, 16'h0001, 16'h0001, 1'b1}, // R6 unmask pending
        '{1'b0, 3'd0, 16'h0000, 16'h0002, 16'h0003, 16'h0001, 1'b1}, // R2 top latches
        '{1'b1, 3'd1, 16'h0001, 16'h0000, 16'h0002, 16'h0001, 1'b0}, // R3 clear one bit
        '{1'b1, 3'd4, 16'h0002, 16'h0000, 16'h0002, 16'h0003, 1'b1}, // R5 set
        '{1'b1, 3'd3, 16'h0001, 16'h0000, 16'h0002, 16'h0002, 1'b1}, // R5 clear
        '{1'b1, 3'd0, 16'hFFFF, 16'h0000, 16'h0002, 16'h0002, 1'b1}, // R8 read-only addr
        '{1'b1, 3'd5, 16'hFFFF, 16'h0000, 16'h0002, 16'h0002, 1'b1}, // R8 unmapped addr
        '{1'b0, 3'd0, 16'h0000, 16'h8004, 16'h8006, 16'h0002, 1'b1}, // R2 reserved bits
        '{1'b1, 3'd1, 16'h0002, 16'h0002, 16'h8006, 16'h0002, 1'b1}, // R4 event beats clear
        '{1'b1, 3'd1, 16'hFFFF, 16'h0000, 16'h0000, 16'h0002, 1'b0}, // R9 status wipe
        '{1'b1, 3'd3, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 1'b0}, // R9 mask wipe
        '{1'b1, 3'd4, 16'h8000, 16'h8000, 16'h8000, 16'h8000, 1'b1}  // R6 set and event together
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // combinational reads, no clock edge involved (R7)
    task automatic read_all(input string req, input logic [15:0] est,
                            input logic [15:0] emk, input logic eirq);
        wr_en = 1'b0; ev_i = '0; rd_en = 1'b1;
        addr = 3'd0; #1 check({req, " R7 status"}, rdata, est);
        addr = 3'd2; #1 check({req, " R7 mask"}, rdata, emk);
        check({req, " R6 irq"}, {15'd0, irq_o}, {15'd0, eirq});
        rd_en = 1'b0;
    endtask

    initial begin
        #2 read_all("R1 reset", 16'h0, 16'h0, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en = VECS[i].wr; addr = VECS[i].a; wdata = VECS[i].d; ev_i = VECS[i].ev;
            @(posedge clk); #2;
            read_all($sformatf("vec%0d", i), VECS[i].est, VECS[i].emk, VECS[i].eirq);
        end
        // R7: unmapped read and idle bus give zero
        rd_en = 1'b1; addr = 3'd6; #1 check("R7 unmapped read", rdata, 16'h0);
        rd_en = 1'b0; addr = 3'd0; #1 check("R7 rd_en low", rdata, 16'h0);
        // R1: reset in mid-operation wipes state
        @(negedge clk); rst_n = 1'b0; #2;
        read_all("R1 mid reset", 16'h0, 16'h0, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        // R2/R6: top-field event with mask already enabled
        @(negedge clk); wr_en = 1'b1; addr = 3'd4; wdata = 16'h0002;
        @(posedge clk); #2 read_all("R6 armed", 16'h0, 16'h0002, 1'b0);
        @(negedge clk); ev_i = 16'h0002;
        @(posedge clk); #2 read_all("R2 top event", 16'h0002, 16'h0002, 1'b1);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule